// File: doc/BRIEF.md
# Bit-Serial Polynomial Remainder Engine

This block divides a serial bit stream by a generator polynomial using modulo-2 arithmetic, one bit per clock. The generator is an input and may change from frame to frame. Its degree `R_W` (up to 32) is fixed by a parameter. A frame opens with a `start` pulse. Bits then arrive most significant first, each one qualified by `bit_valid`, and `bit_last` marks the final bit.

The block runs in one of two modes. In send mode the incoming bits are the message, and the engine produces the `R_W` check bits that make the message followed by those bits an exact multiple of the generator. The check bits appear in parallel on `rem_out` and also leave serially, most significant bit first. In check mode the incoming bits are a complete received codeword, and the engine raises an error flag when the division leaves a nonzero remainder. A generator whose leading coefficient is zero cannot define a remainder of degree `R_W`, so such a generator is refused at the start of the frame.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, `rem_out` is zero and `done`, `crc_err`, `cfg_err` and `crc_bit_valid` are low.
- R2: In the cycle after a `start` pulse, `rem_out` is zero and `done` and `crc_err` are low. The `start` pulse also captures `mode` and `gen`. `start` overrides any bit offered in the same cycle.
- R3: If `gen[R_W]` is 0 at `start`, `cfg_err` is high from the next cycle until the next `start`. For that frame, all bits are ignored, `rem_out` stays zero and `done` stays low.
- R4: With `mode` = 0 (send), when the final message bit is accepted, `rem_out` holds the remainder of the message times 2^R_W divided by the generator, using modulo-2 arithmetic (XOR with no carries). `done` rises in the cycle after that final bit. Example: message 101110 with generator 1001 gives 011.
- R5: In send mode, `crc_bit_valid` is high for exactly `R_W` consecutive cycles, starting in the cycle in which `done` rises. During those cycles `crc_bit` carries the remainder, most significant bit first.
- R6: With `mode` = 1 (check), `crc_err` is registered with `done` in the cycle after the final codeword bit. `crc_err` is 1 exactly when the codeword divided by the generator leaves a nonzero remainder, and `rem_out` holds that remainder. `crc_bit_valid` stays low in check mode.
- R7: `done`, `crc_err` and `rem_out` hold their values until the next `start`. Bits offered after `done` do not change them.
- R8: A cycle with `bit_valid` low leaves the remainder unchanged, whatever the values of `bit_in` and `bit_last`.
- R9: With `R_W` = 32, the generator 1_04C1_1DB7 (hex) gives correct send remainders, accepts unaltered codewords and flags corrupted ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Opens a frame: clears the remainder and captures `mode` and `gen` |
| mode | input | 1 | 0 = send (produce check bits), 1 = check (verify a codeword) |
| gen | input | R_W+1 | Generator polynomial; bit R_W must be 1 |
| bit_in | input | 1 | Serial data bit, most significant first |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_last | input | 1 | Marks the final bit of the frame when `bit_valid` is high |
| rem_out | output | R_W | Running remainder; final remainder once `done` is high |
| crc_bit | output | 1 | Serial check bit in send mode |
| crc_bit_valid | output | 1 | Qualifies `crc_bit` |
| done | output | 1 | Frame complete; held until the next `start` |
| crc_err | output | 1 | Nonzero remainder at the end of a check-mode frame |
| cfg_err | output | 1 | The generator captured at `start` had a zero leading bit |

## Verification
The small configuration (`R_W` = 3) is swept over all eight legal generators. In send mode, every message of one to six bits is applied. In check mode, every codeword of four to eight bits is applied, which covers both valid codewords and every corruption of them. The send sweep separates a correct shift-and-reduce from one that drops the appended zeros or reduces on the wrong term. The check sweep separates zero remainders from nonzero ones for each generator shape, including generators whose constant term is zero. Frames with idle gaps, with bits offered after `done`, and with a refused generator test the hold and ignore rules. A 32-bit run with the standard 33-bit generator tests full-width feedback.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_BAD  = 2'd3
  } crc_state_e;

  localparam logic MODE_SEND  = 1'b0;
  localparam logic MODE_CHECK = 1'b1;

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/crc_div_step.sv
// One modulo-2 division step. In direct form the incoming bit is folded
// into the feedback term, so the remainder of message*2^R_W is ready the
// moment the last message bit arrives. In augmented form the bit enters
// at the bottom of the register, so the result is the remainder of the
// bit string itself.
module crc_div_step #(
  parameter int R_W = 32
) (
  input  logic [R_W-1:0] rem_in,
  input  logic [R_W-1:0] gen_low,
  input  logic           bit_in,
  input  logic           augmented,
  output logic [R_W-1:0] rem_nxt
);

  logic fb;
  logic shift_in;

  assign fb       = augmented ? rem_in[R_W-1] : (rem_in[R_W-1] ^ bit_in);
  assign shift_in = augmented ? bit_in : 1'b0;

  assign rem_nxt[0] = shift_in ^ (fb & gen_low[0]);

  generate
    for (genvar i = 1; i < R_W; i++) begin : g_tap
      assign rem_nxt[i] = rem_in[i-1] ^ (fb & gen_low[i]);
    end
  endgenerate

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import crc_serial_pkg::*;
#(
  parameter int R_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             gen_ok,
  input  logic                             send_mode,
  input  logic                             bit_valid,
  input  logic                             bit_last,
  output logic                             accept,
  output logic                             finish,
  output logic                             done,
  output logic                             cfg_err,
  output logic                             out_valid,
  output logic [$clog2(R_W+1)-1:0]         out_idx
);

  localparam int CNT_W = $clog2(R_W + 1);

  crc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cfg_q, cfg_d;

  assign accept = (state_q == ST_RUN) && bit_valid && !start;
  assign finish = accept && bit_last;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    if (start) begin
      state_d = gen_ok ? ST_RUN : ST_BAD;
      cnt_d   = '0;
      cfg_d   = !gen_ok;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (finish) begin
            state_d = ST_DONE;
            if (send_mode) cnt_d = CNT_W'(R_W);
          end
        end
        ST_DONE: begin
          if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
    end
  end

  assign done      = (state_q == ST_DONE);
  assign cfg_err   = cfg_q;
  assign out_valid = done && (cnt_q != '0);
  assign out_idx   = cnt_q - CNT_W'(1);

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_serial_pkg::*;
#(
  parameter int R_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode,
  input  logic [R_W:0]   gen,
  input  logic           bit_in,
  input  logic           bit_valid,
  input  logic           bit_last,
  output logic [R_W-1:0] rem_out,
  output logic           crc_bit,
  output logic           crc_bit_valid,
  output logic           done,
  output logic           crc_err,
  output logic           cfg_err
);

  localparam int CNT_W = $clog2(R_W + 1);

  logic             rst_n_int;
  logic [R_W-1:0]   rem_q, rem_d, rem_step;
  logic [R_W-1:0]   gen_q, gen_d;
  logic             mode_q, mode_d;
  logic             err_q, err_d;
  logic             accept, finish, out_valid;
  logic [CNT_W-1:0] out_idx;

  crc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  crc_div_step #(.R_W(R_W)) u_div_step (
    .rem_in    (rem_q),
    .gen_low   (gen_q),
    .bit_in    (bit_in),
    .augmented (mode_q == MODE_CHECK),
    .rem_nxt   (rem_step)
  );

  crc_seq_ctrl #(.R_W(R_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .gen_ok    (gen[R_W]),
    .send_mode (mode_q == MODE_SEND),
    .bit_valid (bit_valid),
    .bit_last  (bit_last),
    .accept    (accept),
    .finish    (finish),
    .done      (done),
    .cfg_err   (cfg_err),
    .out_valid (out_valid),
    .out_idx   (out_idx)
  );

  always_comb begin
    rem_d  = rem_q;
    gen_d  = gen_q;
    mode_d = mode_q;
    err_d  = err_q;
    if (start) begin
      rem_d  = '0;
      gen_d  = gen[R_W-1:0];
      mode_d = mode;
      err_d  = 1'b0;
    end else if (accept) begin
      rem_d = rem_step;
      if (finish && (mode_q == MODE_CHECK)) err_d = |rem_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rem_q  <= '0;
      gen_q  <= '0;
      mode_q <= MODE_SEND;
      err_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      gen_q  <= gen_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  // Serial check bits are selected from the held remainder by index, so
  // rem_out stays valid while they stream out.
  always_comb begin
    crc_bit = 1'b0;
    for (int i = 0; i < R_W; i++) begin
      if (out_valid && (out_idx == CNT_W'(i))) crc_bit = rem_q[i];
    end
  end

  assign rem_out       = rem_q;
  assign crc_bit_valid = out_valid;
  assign crc_err       = err_q;

endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
  parameter int R_W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [R_W:0]   gen,
  input logic           bit_valid,
  input logic [R_W-1:0] rem_out,
  input logic           crc_bit_valid,
  input logic           done,
  input logic           crc_err,
  input logic           cfg_err
);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rem_out == '0) && !done && !crc_err);

  p_bad_gen_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !gen[R_W]) |=> cfg_err && !done);

  p_bad_gen_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !done && (rem_out == '0));

  p_serial_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bit_valid |-> done && !crc_err);

  p_err_only_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> done);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(crc_err) && $stable(rem_out));

  p_idle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !start) |=> $stable(rem_out));

endmodule

bind crc_serial_engine crc_serial_engine_chk #(.R_W(R_W)) i_chk (.*);

// File: tb/test_crc_serial_engine.sv
module test_crc_serial_engine;

  logic clk;
  logic rst_n;
  int   n_vec;
  int   n_bad;

  // small configuration, R_W = 3
  logic       s_start, s_mode, s_bit_in, s_bit_valid, s_bit_last;
  logic [3:0] s_gen;
  logic [2:0] s_rem;
  logic       s_crc_bit, s_crc_bit_valid, s_done, s_crc_err, s_cfg_err;

  // wide configuration, R_W = 32
  logic        w_start, w_mode, w_bit_in, w_bit_valid, w_bit_last;
  logic [32:0] w_gen;
  logic [31:0] w_rem;
  logic        w_crc_bit, w_crc_bit_valid, w_done, w_crc_err, w_cfg_err;

  crc_serial_engine #(.R_W(3)) i_crc_serial_engine (
    .clk(clk), .rst_n(rst_n), .start(s_start), .mode(s_mode), .gen(s_gen),
    .bit_in(s_bit_in), .bit_valid(s_bit_valid), .bit_last(s_bit_last),
    .rem_out(s_rem), .crc_bit(s_crc_bit), .crc_bit_valid(s_crc_bit_valid),
    .done(s_done), .crc_err(s_crc_err), .cfg_err(s_cfg_err)
  );

  crc_serial_engine #(.R_W(32)) i_crc_serial_engine_w32 (
    .clk(clk), .rst_n(rst_n), .start(w_start), .mode(w_mode), .gen(w_gen),
    .bit_in(w_bit_in), .bit_valid(w_bit_valid), .bit_last(w_bit_last),
    .rem_out(w_rem), .crc_bit(w_crc_bit), .crc_bit_valid(w_crc_bit_valid),
    .done(w_done), .crc_err(w_crc_err), .cfg_err(w_cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // long division over GF(2), written as an arithmetic reference
  function automatic logic [63:0] pmod(input logic [63:0] v, input int nb,
                                       input logic [63:0] g, input int r);
    logic [63:0] x;
    x = v;
    for (int i = nb - 1; i >= r; i--)
      if (x[i]) x = x ^ (g << (i - r));
    return x & ((64'd1 << r) - 64'd1);
  endfunction

  task automatic run_small(input logic md, input logic [3:0] g,
                           input logic [63:0] data, input int nb,
                           input bit gap, input bit poke);
    logic [63:0] exp_rem;
    logic [63:0] ser;
    logic [2:0]  held;
    bit          sv_ok;
    if (md == 1'b0) exp_rem = pmod(data << 3, nb + 3, {60'd0, g}, 3);
    else            exp_rem = pmod(data, nb, {60'd0, g}, 3);
    s_start = 1'b1; s_mode = md; s_gen = g;
    s_bit_valid = 1'b1; s_bit_in = 1'b1; s_bit_last = 1'b1;
    @(negedge clk);
    s_start = 1'b0; s_bit_valid = 1'b0;
    chk((s_rem == 3'd0) && !s_done && !s_crc_err, "R2 start clears", {61'd0, s_rem}, 64'd0);
    for (int i = nb - 1; i >= 0; i--) begin
      if (gap && (i == nb / 2)) begin
        s_bit_valid = 1'b0; s_bit_in = 1'b1; s_bit_last = 1'b1;
        @(negedge clk);
      end
      s_bit_valid = 1'b1; s_bit_in = data[i]; s_bit_last = (i == 0);
      @(negedge clk);
    end
    s_bit_valid = 1'b0; s_bit_last = 1'b0;
    chk(s_done === 1'b1, md ? "R6 done" : "R4 done", {63'd0, s_done}, 64'd1);
    chk({61'd0, s_rem} == exp_rem, md ? "R6 remainder" : (gap ? "R8 gap remainder" : "R4 remainder"),
        {61'd0, s_rem}, exp_rem);
    if (md == 1'b1) begin
      chk(s_crc_err == (exp_rem != 64'd0), "R6 error flag", {63'd0, s_crc_err}, {63'd0, exp_rem != 64'd0});
      chk(!s_crc_bit_valid, "R6 no serial", {63'd0, s_crc_bit_valid}, 64'd0);
    end else begin
      ser = 64'd0; sv_ok = 1'b1;
      for (int k = 0; k < 3; k++) begin
        if (!s_crc_bit_valid) sv_ok = 1'b0;
        ser = {ser[62:0], s_crc_bit};
        @(negedge clk);
      end
      chk(sv_ok && (ser == exp_rem), "R5 serial bits", ser, exp_rem);
      chk(!s_crc_bit_valid, "R5 serial length", {63'd0, s_crc_bit_valid}, 64'd0);
    end
    if (poke) begin
      held = s_rem;
      s_bit_valid = 1'b1; s_bit_in = 1'b1; s_bit_last = 1'b1;
      @(negedge clk);
      s_bit_valid = 1'b0; s_bit_last = 1'b0;
      chk(s_done && (s_rem == held) && (s_crc_err == (md && exp_rem != 64'd0)),
          "R7 hold after done", {61'd0, s_rem}, {61'd0, held});
    end
  endtask

  task automatic run_wide(input logic md, input logic [63:0] data, input int nb,
                          output logic [31:0] rem, output logic err);
    w_start = 1'b1; w_mode = md; w_gen = 33'h1_04C1_1DB7;
    @(negedge clk);
    w_start = 1'b0;
    for (int i = nb - 1; i >= 0; i--) begin
      w_bit_valid = 1'b1; w_bit_in = data[i]; w_bit_last = (i == 0);
      @(negedge clk);
    end
    w_bit_valid = 1'b0; w_bit_last = 1'b0;
    rem = w_rem; err = w_crc_err;
    chk(w_done === 1'b1, "R9 done", {63'd0, w_done}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] wr;
    logic        we;
    logic [63:0] wexp;
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0;
    s_start = 0; s_mode = 0; s_gen = 4'd0; s_bit_in = 0; s_bit_valid = 0; s_bit_last = 0;
    w_start = 0; w_mode = 0; w_gen = 33'd0; w_bit_in = 0; w_bit_valid = 0; w_bit_last = 0;
    repeat (3) @(negedge clk);
    chk((s_rem == 3'd0) && !s_done && !s_crc_err && !s_cfg_err && !s_crc_bit_valid,
        "R1 reset state", {61'd0, s_rem}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!w_done && (w_rem == 32'd0) && !w_cfg_err, "R1 reset state wide", {32'd0, w_rem}, 64'd0);

    // worked example: 101110 with 1001 gives 011
    run_small(1'b0, 4'b1001, 64'b101110, 6, 1'b0, 1'b0);
    chk(s_done && (s_rem == 3'b011), "R4 worked example", {61'd0, s_rem}, 64'd3);
    run_small(1'b1, 4'b1001, 64'b101110011, 9, 1'b0, 1'b1);
    chk(!s_crc_err, "R6 worked codeword accepted", {63'd0, s_crc_err}, 64'd0);

    // refused generator
    s_start = 1'b1; s_mode = 1'b0; s_gen = 4'b0111;
    @(negedge clk);
    s_start = 1'b0;
    chk(s_cfg_err === 1'b1, "R3 cfg_err raised", {63'd0, s_cfg_err}, 64'd1);
    for (int i = 0; i < 4; i++) begin
      s_bit_valid = 1'b1; s_bit_in = 1'b1; s_bit_last = (i == 3);
      @(negedge clk);
    end
    s_bit_valid = 1'b0; s_bit_last = 1'b0;
    chk(!s_done && (s_rem == 3'd0) && s_cfg_err, "R3 bits ignored", {61'd0, s_rem}, 64'd0);
    s_start = 1'b1; s_gen = 4'b1011;
    @(negedge clk);
    s_start = 1'b0;
    chk(!s_cfg_err, "R3 cleared by good start", {63'd0, s_cfg_err}, 64'd0);

    // exhaustive send sweep
    for (int g = 8; g < 16; g++)
      for (int d = 1; d <= 6; d++)
        for (int m = 0; m < (1 << d); m++)
          run_small(1'b0, 4'(g), 64'(m), d, (m % 3) == 0, (m % 5) == 0);

    // exhaustive check sweep
    for (int g = 8; g < 16; g++)
      for (int n = 4; n <= 8; n++)
        for (int c = 0; c < (1 << n); c++)
          run_small(1'b1, 4'(g), 64'(c), n, (c % 7) == 0, (c % 4) == 0);

    // wide generator
    wexp = pmod(64'h0000_0000_3132_3334 << 32, 64, 64'h1_04C1_1DB7, 32);
    run_wide(1'b0, 64'h3132_3334, 32, wr, we);
    chk({32'd0, wr} == wexp, "R9 send remainder", {32'd0, wr}, wexp);
    run_wide(1'b1, {32'h3132_3334, wexp[31:0]}, 64, wr, we);
    chk(!we && (wr == 32'd0), "R9 codeword accepted", {63'd0, we}, 64'd0);
    run_wide(1'b1, {32'h3132_3334, wexp[31:0]} ^ 64'h0000_0400_0000_0000, 64, wr, we);
    chk(we === 1'b1, "R9 corrupted codeword flagged", {63'd0, we}, 64'd1);
    run_wide(1'b1, {32'h3132_3334, wexp[31:0]} ^ 64'h0000_0000_00F0_0000, 64, wr, we);
    chk(we === 1'b1, "R9 burst flagged", {63'd0, we}, 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule